// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes a received Ethernet frame, delivered as a byte stream with first-byte and last-byte markers, and stores it in a circular buffer in local packet memory. The buffer is organised in 256-byte pages. It runs from a programmable start page up to, but not including, a programmable stop page. Each stored frame occupies whole pages. Its first page begins with a 4-byte descriptor. The descriptor holds a good-frame status code, the page where the next frame will begin, and the stored length.

The frame length is not known until the last byte arrives. The writer therefore streams the payload in first, starting four bytes into the current page, and writes the descriptor afterwards. Once the descriptor is complete, the current-page pointer moves to the next free page and a one-cycle done pulse is raised. The writer also computes, from the current page and the read boundary page, whether a maximum-size frame still fits. A frame that starts while space is short, or while the receiver is stopped, is swallowed without touching memory.

The state machine has five states. IDLE waits for a first byte. STORE takes payload bytes. DROP discards a refused frame up to its last byte. PAD appends zero bytes to short frames. HDR writes the four descriptor bytes. The transitions are as follows:
- IDLE→STORE on an accepted first byte.
- IDLE→PAD on an accepted one-byte frame.
- IDLE→DROP on a refused first byte that is not also last.
- STORE→PAD or STORE→HDR on the last byte, depending on the length so far.
- DROP→IDLE on the last byte.
- PAD→HDR once 60 bytes are stored.
- HDR→IDLE after the fourth descriptor byte, which is also the commit.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_pg` is 0, `s_ready` is 1, and `mem_we` and `rx_done` are 0.
- R2: A frame whose first byte arrives while `rx_stopped` is 1 causes no memory write and no `rx_done`, and leaves `cur_pg` unchanged. All of its bytes are still accepted.
- R3: `space_ok` is 1 exactly when `rx_stopped` is 0 and the free space is at least 1518 bytes. Free space is (bnd−cur)×256 when cur<bnd, and otherwise (stop−start)×256 − (cur−bnd)×256. A frame that starts while `space_ok` is 0 is discarded as in R2.
- R4: Payload byte i of an accepted frame is written to address cur×256+4+i, where the address is {page, byte}. No other addresses are written, apart from the padding and the descriptor.
- R5: When the payload write address reaches stop×256, it continues at start×256.
- R6: A frame shorter than 60 bytes is followed by zero bytes until 60 bytes are stored. A frame of 60 bytes or more gets no padding.
- R7: The descriptor is written at cur×256 + 0..3 after the payload. The bytes are:
  - offset 0: 0x01
  - offset 1: the next page
  - offset 2: total length bits 7:0
  - offset 3: total length bits 15:8
  The total length is the stored length plus 4.
- R8: The next page is cur + ceil((total+4)/256), minus (stop−start) if that result is at least stop. In the cycle after the last descriptor write, `rx_done` is 1 for exactly one cycle and `cur_pg` already shows the next page.
- R9: `s_ready` is 0 from the cycle after an accepted frame's last byte until its descriptor is complete.
- R10: A pulse on `cur_load` sets `cur_pg` to `cur_load_pg` on the next clock edge.
- R11: Bytes that arrive in IDLE without the first-byte marker are accepted and cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the ring's end |
| ring_bnd_pg | input | 8 | Read boundary page held by the consumer |
| rx_stopped | input | 1 | Receiver stopped; new frames are refused |
| cur_load | input | 1 | Load `cur_load_pg` into the current page |
| cur_load_pg | input | 8 | Value for the current page load |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when valid |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the last of a frame |
| s_data | input | 8 | Stream byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | 8 | Current receive page |
| space_ok | output | 1 | A maximum-size frame would be accepted now |
| rx_done | output | 1 | One-cycle pulse when a frame is committed |

## Verification
The bench goes after several corner cases; each is listed with the fault it would expose.
- A payload that crosses the stop page: it would show a design that wraps one byte late or writes past the ring's end.
- A frame whose next-page sum lands exactly on the stop page: it catches a `>` used where `>=` belongs, which would leave the pointer outside the ring.
- Frames of 1, 10 and exactly 60 bytes: they expose padding that is off by one, or padding that is missing or non-zero.
- A boundary that leaves five pages free, and then one that leaves six: they expose a space threshold applied in bytes instead of whole pages, or off by one page.
- Frames that arrive while stopped, and stray bytes in IDLE: a careless writer would spill these into memory.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STORE,
        ST_DROP,
        ST_PAD,
        ST_HDR
    } rrw_state_e;

    localparam int DESC_BYTES = 4;
    localparam int CRC_BYTES  = 4;
    localparam logic [7:0] STAT_GOOD = 8'h01;

endpackage

// File: rtl/rrw_space_check.sv
module rrw_space_check #(
    parameter int PG_W    = 8,
    parameter int NEED_PG = 6
) (
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bnd_pg,
    input  logic [PG_W-1:0] cur_pg,
    input  logic            stopped,
    output logic            room_ok
);
    localparam int SW = PG_W + 2;

    logic signed [SW-1:0] s_start, s_stop, s_bnd, s_cur, avail;

    assign s_start = $signed({2'b00, start_pg});
    assign s_stop  = $signed({2'b00, stop_pg});
    assign s_bnd   = $signed({2'b00, bnd_pg});
    assign s_cur   = $signed({2'b00, cur_pg});

    always_comb begin
        if (cur_pg < bnd_pg) begin
            avail = s_bnd - s_cur;
        end else begin
            avail = (s_stop - s_start) - (s_cur - s_bnd);
        end
    end

    assign room_ok = !stopped && (avail >= $signed(SW'(NEED_PG)));

endmodule

// File: rtl/rrw_next_page.sv
module rrw_next_page #(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8,
    parameter int LEN_W = 16,
    parameter int TAIL  = 4
) (
    input  logic [PG_W-1:0]  base_pg,
    input  logic [PG_W-1:0]  start_pg,
    input  logic [PG_W-1:0]  stop_pg,
    input  logic [LEN_W-1:0] total_len,
    output logic [PG_W-1:0]  next_pg
);
    localparam int W = LEN_W + PG_W + 2;
    localparam int ROUND = (1 << OFF_W) - 1;

    logic [W-1:0] adv, sum, span, wrapped;

    always_comb begin
        adv     = (W'(total_len) + W'(TAIL) + W'(ROUND)) >> OFF_W;
        sum     = W'(base_pg) + adv;
        span    = W'(stop_pg) - W'(start_pg);
        wrapped = (sum >= W'(stop_pg)) ? (sum - span) : sum;
        next_pg = wrapped[PG_W-1:0];
    end

endmodule

// File: rtl/rrw_ptr_step.sv
module rrw_ptr_step #(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8
) (
    input  logic [PG_W+OFF_W-1:0] ptr,
    input  logic [PG_W-1:0]       start_pg,
    input  logic [PG_W-1:0]       stop_pg,
    output logic [PG_W+OFF_W-1:0] ptr_nxt
);
    localparam int AW = PG_W + OFF_W;

    logic [AW-1:0] inc;

    always_comb begin
        inc = ptr + AW'(1);
        if (inc == {stop_pg, {OFF_W{1'b0}}}) begin
            ptr_nxt = {start_pg, {OFF_W{1'b0}}};
        end else begin
            ptr_nxt = inc;
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rrw_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int OFF_W     = 8,
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PG_W-1:0]       ring_start_pg,
    input  logic [PG_W-1:0]       ring_stop_pg,
    input  logic [PG_W-1:0]       ring_bnd_pg,
    input  logic                  rx_stopped,
    input  logic                  cur_load,
    input  logic [PG_W-1:0]       cur_load_pg,
    input  logic                  s_valid,
    output logic                  s_ready,
    input  logic                  s_first,
    input  logic                  s_last,
    input  logic [7:0]            s_data,
    output logic                  mem_we,
    output logic [PG_W+OFF_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic [PG_W-1:0]       cur_pg,
    output logic                  space_ok,
    output logic                  rx_done
);
    localparam int ADDR_W     = PG_W + OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int NEED_PG    = (MAX_FRAME + CRC_BYTES + PAGE_BYTES - 1) / PAGE_BYTES;
    localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);
    localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(DESC_BYTES);

    rrw_state_e         state_q, state_d;
    logic [PG_W-1:0]    base_q, base_d;
    logic [ADDR_W-1:0]  ptr_q, ptr_d;
    logic [LEN_W-1:0]   len_q, len_d;
    logic [1:0]         hidx_q, hidx_d;
    logic [PG_W-1:0]    cur_q;
    logic               done_q;
    logic               commit;
    logic               take;
    logic [LEN_W-1:0]   len_inc;
    logic [LEN_W-1:0]   total_len;
    logic [PG_W-1:0]    next_pg;
    logic [ADDR_W-1:0]  ptr_nxt;
    logic               room_ok;

    assign take      = s_valid && s_ready;
    assign len_inc   = len_q + ONE_LEN;
    assign total_len = len_q + LEN_W'(DESC_BYTES);
    assign cur_pg    = cur_q;
    assign rx_done   = done_q;
    assign space_ok  = room_ok;

    rrw_space_check #(.PG_W(PG_W), .NEED_PG(NEED_PG)) u_space (
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .bnd_pg   (ring_bnd_pg),
        .cur_pg   (cur_q),
        .stopped  (rx_stopped),
        .room_ok  (room_ok)
    );

    rrw_next_page #(.PG_W(PG_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .TAIL(CRC_BYTES)) u_next (
        .base_pg   (base_q),
        .start_pg  (ring_start_pg),
        .stop_pg   (ring_stop_pg),
        .total_len (total_len),
        .next_pg   (next_pg)
    );

    rrw_ptr_step #(.PG_W(PG_W), .OFF_W(OFF_W)) u_step (
        .ptr      (mem_addr),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .ptr_nxt  (ptr_nxt)
    );

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            ptr_q   <= '0;
            len_q   <= '0;
            hidx_q  <= '0;
            cur_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            ptr_q   <= ptr_d;
            len_q   <= len_d;
            hidx_q  <= hidx_d;
            done_q  <= commit;
            if (commit) begin
                cur_q <= next_pg;
            end else if (cur_load) begin
                cur_q <= cur_load_pg;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        ptr_d   = ptr_q;
        len_d   = len_q;
        hidx_d  = hidx_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take && s_first) begin
                    if (room_ok) begin
                        base_d = cur_q;
                        ptr_d  = ptr_nxt;
                        len_d  = ONE_LEN;
                        hidx_d = '0;
                        if (s_last) begin
                            state_d = (ONE_LEN < MIN_LEN) ? ST_PAD : ST_HDR;
                        end else begin
                            state_d = ST_STORE;
                        end
                    end else if (!s_last) begin
                        state_d = ST_DROP;
                    end
                end
            end
            ST_STORE: begin
                if (take) begin
                    ptr_d = ptr_nxt;
                    len_d = len_inc;
                    if (s_last) begin
                        hidx_d  = '0;
                        state_d = (len_inc < MIN_LEN) ? ST_PAD : ST_HDR;
                    end
                end
            end
            ST_DROP: begin
                if (take && s_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PAD: begin
                ptr_d = ptr_nxt;
                len_d = len_inc;
                if (len_inc >= MIN_LEN) begin
                    hidx_d  = '0;
                    state_d = ST_HDR;
                end
            end
            ST_HDR: begin
                hidx_d = hidx_q + 2'd1;
                if (hidx_q == 2'd3) begin
                    state_d = ST_IDLE;
                    commit  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        s_ready   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                s_ready   = 1'b1;
                mem_we    = s_valid && s_first && room_ok;
                mem_addr  = {cur_q, DATA_OFF};
                mem_wdata = s_data;
            end
            ST_STORE: begin
                s_ready   = 1'b1;
                mem_we    = s_valid;
                mem_wdata = s_data;
            end
            ST_DROP: begin
                s_ready = 1'b1;
            end
            ST_PAD: begin
                mem_we    = 1'b1;
                mem_wdata = 8'h00;
            end
            ST_HDR: begin
                mem_we   = 1'b1;
                mem_addr = {base_q, OFF_W'(hidx_q)};
                unique case (hidx_q)
                    2'd0: mem_wdata = STAT_GOOD;
                    2'd1: mem_wdata = 8'(next_pg);
                    2'd2: mem_wdata = total_len[7:0];
                    2'd3: mem_wdata = 8'(total_len >> 8);
                    default: mem_wdata = 8'h00;
                endcase
            end
            default: ;
        endcase
    end

    // Assertions
    assert_stopped_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_stopped) |-> !mem_we)
        else $error("write while stopped in idle");

    assert_ring_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (state_q == ST_STORE || state_q == ST_PAD) && ring_start_pg != ring_stop_pg)
        |-> (mem_addr != {ring_stop_pg, {OFF_W{1'b0}}}))
        else $error("payload address reached stop page");

    assert_padded_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR) |-> (len_q >= MIN_LEN))
        else $error("descriptor written for short frame");

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done)
        else $error("done longer than one cycle");

    assert_done_after_desc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> ($past(mem_we) && !$past(s_ready)))
        else $error("done without preceding descriptor write");

endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ring_start_pg = 8'h40;
    logic [7:0]  ring_stop_pg  = 8'h80;
    logic [7:0]  ring_bnd_pg   = 8'h40;
    logic        rx_stopped = 1'b1;
    logic        cur_load = 1'b0;
    logic [7:0]  cur_load_pg = 8'h00;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        s_first = 1'b0;
    logic        s_last = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic        space_ok;
    logic        rx_done;

    always #10 clk = ~clk;

    rx_ring_writer u_rx_ring_writer (
        .clk(clk), .rst_n(rst_n),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg), .ring_bnd_pg(ring_bnd_pg),
        .rx_stopped(rx_stopped), .cur_load(cur_load), .cur_load_pg(cur_load_pg),
        .s_valid(s_valid), .s_ready(s_ready), .s_first(s_first), .s_last(s_last), .s_data(s_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .space_ok(space_ok), .rx_done(rx_done)
    );

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int cur_at_done = -1;
    int model_cur = 0;
    bit finished = 0;
    logic [7:0] dut_mem [int];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic end_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    function automatic bit model_room(input int cur);
        int av;
        int st = int'(ring_start_pg);
        int sp = int'(ring_stop_pg);
        int bd = int'(ring_bnd_pg);
        if (cur < bd) av = (bd - cur) * 256;
        else av = (sp - st) * 256 - (cur - bd) * 256;
        return !rx_stopped && (av >= 1518);
    endfunction

    function automatic int rd(input int a);
        if (dut_mem.exists(a)) return int'(dut_mem[a]);
        return -1;
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7 + (i >> 3)) & 255);
    endfunction

    // Monitor: sampled away from the active edge; R3 compared every clock
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (mem_we) begin
                dut_mem[int'(mem_addr)] = mem_wdata;
                wr_cnt++;
            end
            if (rx_done) begin
                done_cnt++;
                cur_at_done = int'(cur_pg);
            end
            chk(space_ok == model_room(int'(cur_pg)), "R3 space_ok", int'(space_ok),
                int'(model_room(int'(cur_pg))));
        end
        if (cycles > 100000) begin
            chk(0, "watchdog", cycles, 100000);
            end_run();
        end
    end

    task automatic push(input logic [7:0] d, input bit f, input bit l);
        bit r;
        s_valid = 1'b1; s_data = d; s_first = f; s_last = l;
        forever begin
            @(negedge clk);
            r = s_ready;
            @(posedge clk);
            #2;
            if (r) break;
        end
        s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
    endtask

    task automatic load_cur(input int v);
        cur_load = 1'b1; cur_load_pg = 8'(v);
        @(posedge clk); #2;
        cur_load = 1'b0;
        @(negedge clk);
        chk(cur_pg == 8'(v), "R10 cur load", int'(cur_pg), v);
        model_cur = v;
        @(posedge clk); #2;
    endtask

    task automatic run_frame(input int n, input int seed, input string rtag);
        int plen, total, nxt_b, nxt_pg, base, a, st, sp;
        bit acc, wrapped;
        st = int'(ring_start_pg);
        sp = int'(ring_stop_pg);
        acc = model_room(model_cur);
        plen = (n < 60) ? 60 : n;
        total = plen + 4;
        base = model_cur * 256;
        nxt_b = base + ((total + 4 + 255) / 256) * 256;
        if (nxt_b >= sp * 256) nxt_b -= (sp - st) * 256;
        nxt_pg = nxt_b / 256;
        dut_mem.delete();
        wr_cnt = 0; done_cnt = 0; cur_at_done = -1;
        for (int i = 0; i < n; i++) push(pat(seed, i), i == 0, i == n - 1);
        @(negedge clk);
        if (acc) chk(s_ready == 1'b0, "R9 ready after last", int'(s_ready), 0);
        repeat (80) @(posedge clk);
        #2;
        if (acc) begin
            chk(done_cnt == 1, "R8 done pulses", done_cnt, 1);
            chk(cur_at_done == nxt_pg, "R8 cur at done", cur_at_done, nxt_pg);
            chk(int'(cur_pg) == nxt_pg, "R8 next page", int'(cur_pg), nxt_pg);
            chk(wr_cnt == plen + 4, "R4 write count", wr_cnt, plen + 4);
            chk(rd(base) == 1, "R7 status byte", rd(base), 1);
            chk(rd(base + 1) == nxt_pg, "R7 next page byte", rd(base + 1), nxt_pg);
            chk(rd(base + 2) == (total & 255), "R7 length low", rd(base + 2), total & 255);
            chk(rd(base + 3) == (total >> 8), "R7 length high", rd(base + 3), total >> 8);
            a = base + 4;
            wrapped = 0;
            for (int i = 0; i < plen; i++) begin
                if (i < n) begin
                    if (wrapped) chk(rd(a) == int'(pat(seed, i)), "R5 wrapped byte", rd(a), int'(pat(seed, i)));
                    else chk(rd(a) == int'(pat(seed, i)), "R4 payload byte", rd(a), int'(pat(seed, i)));
                end else begin
                    chk(rd(a) == 0, "R6 pad byte", rd(a), 0);
                end
                a++;
                if (a == sp * 256) begin
                    a = st * 256;
                    wrapped = 1;
                end
            end
            model_cur = nxt_pg;
        end else begin
            chk(wr_cnt == 0, {rtag, " refused writes"}, wr_cnt, 0);
            chk(done_cnt == 0, {rtag, " refused done"}, done_cnt, 0);
            chk(int'(cur_pg) == model_cur, {rtag, " refused cur"}, int'(cur_pg), model_cur);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(cur_pg == 8'h00, "R1 reset cur", int'(cur_pg), 0);
        chk(s_ready == 1'b1, "R1 reset ready", int'(s_ready), 1);
        chk(mem_we == 1'b0, "R1 reset we", int'(mem_we), 0);
        chk(rx_done == 1'b0, "R1 reset done", int'(rx_done), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;

        load_cur(8'h40);
        run_frame(80, 3, "R2");          // stopped: refused

        rx_stopped = 1'b0;
        @(posedge clk); #2;

        // R11: stray bytes in idle
        wr_cnt = 0; done_cnt = 0;
        push(8'hAA, 1'b0, 1'b0);
        push(8'h55, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        #2;
        chk(wr_cnt == 0, "R11 stray writes", wr_cnt, 0);
        chk(int'(cur_pg) == model_cur, "R11 stray cur", int'(cur_pg), model_cur);

        run_frame(100, 11, "R4");
        run_frame(10, 20, "R6");
        run_frame(1, 33, "R6");
        run_frame(60, 47, "R6");

        ring_bnd_pg = 8'h50;
        load_cur(8'h7F);
        run_frame(300, 5, "R5");         // payload wraps; next page wraps

        load_cur(8'h7E);
        run_frame(252, 9, "R8");         // next page lands exactly on stop

        load_cur(8'h45);
        ring_bnd_pg = 8'h4A;             // five pages free
        @(posedge clk); #2;
        run_frame(100, 2, "R3");
        ring_bnd_pg = 8'h4B;             // six pages free
        @(posedge clk); #2;
        run_frame(1514, 77, "R3");

        ring_bnd_pg = cur_pg;            // empty ring: full space
        repeat (3) @(posedge clk);
        #2;
        run_frame(64, 100, "R4");

        end_run();
    end

endmodule